// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked request interface and a 16-bit asynchronous static RAM. A requester presents one read or one write with an address, write data and a per-byte mask. The block turns it into the chip-enable, output-enable, write-enable and byte-select pin sequence that the memory needs. It also drives or releases the shared data bus. For a read it returns the captured word together with a single-cycle completion pulse.

Each analogue timing limit is given as a parameter in picoseconds. The block converts it into a whole number of clock cycles, rounding up, and never uses fewer than one cycle. Write enable falls only after output enable has been high for a guard interval. Each written word ends when its byte selects rise while write enable stays low. After a write, write enable stays low in idle, so a following write starts at once with no guard phase. A following read first spends one recovery cycle with write enable high.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0, the chip enable, output enable, write enable and both byte selects are high, and the data bus is not driven.
- R2: A request is taken only when req_valid is high and busy is low. From the cycle after acceptance through the cycle in which done is high, busy is 1. A request presented while busy is ignored and produces no memory access and no done pulse. mem_addr holds still for as long as busy stays high.
- R3: For a write that does not follow another write, output enable is high for at least ceil(T_OE_GUARD_PS/T_CLK_PS) cycles (default 1) before write enable falls. Done appears 1 + guard + active cycles after the accepting edge.
- R4: The write window (chip enable, write enable and a byte select all low) lasts exactly max(ceil(T_WE_PW_PS/T_CLK_PS), ceil(T_DS_PS/T_CLK_PS), ceil(T_WC_PS/T_CLK_PS)-1) cycles (default 1). It ends when the byte selects rise while chip enable and write enable are still low, with address and write data unchanged on that edge. The done pulse accompanies this end cycle.
- R5: After a write completes, write enable stays low in idle. A following write skips the guard phase, so its done appears 1 + active cycles after acceptance (default 2).
- R6: A read drives chip enable and output enable low, with write enable high and the byte selects following the mask, for max(ceil(T_RC_PS/T_CLK_PS), ceil(T_AA_PS/T_CLK_PS), ceil(T_OE_ACC_PS/T_CLK_PS)) cycles (default 2). The word is captured on the last of these cycles, and done rises in the next cycle with rd_data valid. The default latency from acceptance is 3 cycles.
- R7: A read that follows a write first spends one cycle with chip enable and write enable high before output enable falls. This adds one cycle of latency (default 4).
- R8: Mask bit 0 selects the lower byte (data bits 7:0, mem_bs_n[0]) and bit 1 the upper byte (bits 15:8, mem_bs_n[1]). A write with a mask bit at 0 leaves that byte of memory unchanged. A read returns 0 in every lane whose mask bit is 0.
- R9: The data bus is driven only while the write window is open and during the cycle that ends it. It is never driven while output enable is low, and output enable and write enable are never low together.
- R10: done is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte enable, bit 0 lower byte, bit 1 upper byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| rd_data | output | 16 | Captured read word, unselected lanes zero |
| mem_addr | output | 19 | Memory address bus |
| mem_dout | output | 16 | Data to the bus |
| mem_doe | output | 1 | Enable for the bus drivers |
| mem_din | input | 16 | Data from the bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Byte selects, active low, bit 0 lower, bit 1 upper |

## Verification
Several rules are checked on every cycle by properties: bus ownership never overlaps output enable, output enable and write enable are never both low, write enable falls only after output enable has been high, each write window ends by the byte selects with address and data held, done is a single pulse, and the address is stable while busy. Other behaviour can only be seen through the bench's scenarios. These are the stored contents seen through later reads, lane masking, cycle latencies that depend on whether a write came before, the exact window lengths, and a request ignored while busy. The bench observes them with a pin-level memory model and a scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_GUARD,
    ST_WR_ACT,
    ST_WR_HOLD,
    ST_RD_REC,
    ST_RD_ACT,
    ST_RD_FIN
  } sram_st_e;

  // Round a time up to whole clock cycles, never below one.
  function automatic int unsigned ps_to_cycles(input int unsigned ps, input int unsigned clk_ps);
    int unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_timer.sv
module sram_timer #(
  parameter int unsigned TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_fsm.sv
module sram_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned GUARD_CYC = 1,
  parameter int unsigned WACT_CYC  = 1,
  parameter int unsigned RACT_CYC  = 2,
  parameter int unsigned TW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          is_write,
  input  logic          expired,
  output sram_st_e      state,
  output logic          we_held,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val
);
  sram_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (is_write) nxt = we_held ? ST_WR_ACT : ST_WR_GUARD;
        else          nxt = we_held ? ST_RD_REC : ST_RD_ACT;
      end
      ST_WR_GUARD: if (expired) nxt = ST_WR_ACT;
      ST_WR_ACT:   if (expired) nxt = ST_WR_HOLD;
      ST_WR_HOLD:  nxt = ST_IDLE;
      ST_RD_REC:   nxt = ST_RD_ACT;
      ST_RD_ACT:   if (expired) nxt = ST_RD_FIN;
      ST_RD_FIN:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (nxt != state);

  always_comb begin
    unique case (nxt)
      ST_WR_GUARD: tmr_val = TW'(GUARD_CYC - 1);
      ST_WR_ACT:   tmr_val = TW'(WACT_CYC - 1);
      ST_RD_ACT:   tmr_val = TW'(RACT_CYC - 1);
      default:     tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      we_held <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_WR_HOLD)     we_held <= 1'b1;
      else if (state == ST_RD_REC) we_held <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  sram_st_e        state,
  input  logic [NB-1:0]   mask,
  input  logic            we_held,
  output logic            ce_n,
  output logic            oe_n,
  output logic            we_n,
  output logic [NB-1:0]   bs_n,
  output logic            doe
);
  always_comb begin
    ce_n = 1'b1;
    oe_n = 1'b1;
    we_n = 1'b1;
    bs_n = '1;
    doe  = 1'b0;
    unique case (state)
      ST_IDLE:     we_n = ~we_held;
      ST_WR_GUARD: ce_n = 1'b0;
      ST_WR_ACT: begin
        ce_n = 1'b0; we_n = 1'b0; bs_n = ~mask; doe = 1'b1;
      end
      ST_WR_HOLD: begin
        ce_n = 1'b0; we_n = 1'b0; doe = 1'b1;
      end
      ST_RD_ACT: begin
        ce_n = 1'b0; oe_n = 1'b0; bs_n = ~mask;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 19,
  parameter int unsigned DW            = 16,
  parameter int unsigned T_CLK_PS      = 8000,
  parameter int unsigned T_OE_GUARD_PS = 4000,
  parameter int unsigned T_WE_PW_PS    = 8000,
  parameter int unsigned T_DS_PS       = 6000,
  parameter int unsigned T_WC_PS       = 10000,
  parameter int unsigned T_RC_PS       = 10000,
  parameter int unsigned T_AA_PS       = 10000,
  parameter int unsigned T_OE_ACC_PS   = 6500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_mask,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe,
  input  logic [DW-1:0]     mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DW/8-1:0]   mem_bs_n
);
  localparam int unsigned NB        = DW / 8;
  localparam int unsigned GUARD_CYC = ps_to_cycles(T_OE_GUARD_PS, T_CLK_PS);
  localparam int unsigned WC_CYC    = ps_to_cycles(T_WC_PS, T_CLK_PS);
  localparam int unsigned WACT_CYC  = max3(ps_to_cycles(T_WE_PW_PS, T_CLK_PS),
                                           ps_to_cycles(T_DS_PS, T_CLK_PS), WC_CYC - 1);
  localparam int unsigned RACT_CYC  = max3(ps_to_cycles(T_RC_PS, T_CLK_PS),
                                           ps_to_cycles(T_AA_PS, T_CLK_PS),
                                           ps_to_cycles(T_OE_ACC_PS, T_CLK_PS));
  localparam int unsigned MAX_CYC   = max3(GUARD_CYC, WACT_CYC, RACT_CYC);
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  sram_st_e          state;
  logic              we_held, tmr_load, expired;
  logic [TW-1:0]     tmr_val;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rd_q, cap_val;
  logic [NB-1:0]     mask_q;

  // Named internal events, observed by the checker.
  logic accept, cap_evt, wr_win;
  assign accept  = req_valid && (state == ST_IDLE);
  assign cap_evt = (state == ST_RD_ACT) && expired;
  assign wr_win  = !mem_ce_n && !mem_we_n && (mem_bs_n != '1);

  sram_fsm #(
    .GUARD_CYC(GUARD_CYC), .WACT_CYC(WACT_CYC), .RACT_CYC(RACT_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_write(req_write),
    .expired(expired), .state(state), .we_held(we_held),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  sram_pins #(.NB(NB)) u_pins (
    .state(state), .mask(mask_q), .we_held(we_held),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .bs_n(mem_bs_n), .doe(mem_doe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign cap_val[g*8 +: 8] = mask_q[g] ? mem_din[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (cap_evt) rd_q <= cap_val;
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_WR_HOLD) || (state == ST_RD_FIN);
  assign rd_data  = rd_q;
  assign mem_addr = addr_q;
  assign mem_dout = wdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wr_win,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_doe,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n
);
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> mem_oe_n);

  assert_oe_we_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  assert_guard_before_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n));

  assert_end_by_bytesel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_win) && !wr_win) |-> (!mem_ce_n && !mem_we_n && mem_doe
                                    && $stable(mem_addr) && $stable(mem_dout)));

  assert_recover_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(mem_we_n));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wr_win(wr_win),
  .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int CLK_PS = 8000;

  function automatic int cyc_of(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int G = cyc_of(4000);
  localparam int W = imax(imax(cyc_of(8000), cyc_of(6000)), cyc_of(10000) - 1);
  localparam int R = imax(imax(cyc_of(10000), cyc_of(10000)), cyc_of(6500));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic busy, done, mem_doe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [15:0] rd_data, mem_dout;
  logic [15:0] mem_din = 16'hFFFF;
  logic [18:0] mem_addr;
  logic [1:0]  mem_bs_n;

  always #4ns clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n)
  );

  int checks = 0, errors = 0, cyc = 0, issued = 0, dones = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- pin-level memory model ----------------
  logic [15:0] smem [int];
  logic p_ce = 1, p_we = 1;
  logic [1:0] p_bs = 2'b11;
  logic [18:0] p_addr = '0;
  logic [15:0] p_dout = '0;

  always @(negedge clk) begin
    for (int l = 0; l < 2; l++) begin
      if (!p_ce && !p_we && !p_bs[l] && !(!mem_ce_n && !mem_we_n && !mem_bs_n[l])) begin
        logic [15:0] w;
        w = smem.exists(int'(p_addr)) ? smem[int'(p_addr)] : 16'h0000;
        w[l*8 +: 8] = p_dout[l*8 +: 8];
        smem[int'(p_addr)] = w;
      end
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_bs = mem_bs_n;
    p_addr = mem_addr; p_dout = mem_dout;
    begin
      logic [15:0] o, w;
      o = 16'hFFFF;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        w = smem.exists(int'(mem_addr)) ? smem[int'(mem_addr)] : 16'h0000;
        if (!mem_bs_n[0]) o[7:0]  = w[7:0];
        if (!mem_bs_n[1]) o[15:8] = w[15:8];
      end
      mem_din = o;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [15:0] data; int lat; int t0; } item_t;
  item_t sb[$];
  logic [15:0] ref_mem [int];
  bit prev_write = 0;

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    item_t it;
    logic [15:0] cur;
    @(negedge clk);
    while (busy) @(negedge clk);
    cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    it.rd = !wr;
    it.t0 = cyc;
    if (wr) begin
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
      it.data = '0;
      it.lat  = prev_write ? (1 + W) : (1 + G + W);
    end else begin
      it.data = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
      it.lat  = prev_write ? (2 + R) : (1 + R);
    end
    sb.push_back(it);
    issued++;
    prev_write = wr;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: completions and pin timing
  int win_run = 0, oe_run = 0;
  bit p_oe_n = 1, p_we_n = 1, was_wr_done = 0;
  always @(negedge clk) if (rst_n) begin
    if (done) begin
      dones++;
      if (sb.size() == 0) check(0, "R10", "done without request", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(cyc - it.t0 == it.lat, it.rd ? (prev_write ? "R7" : "R6") : "R3/R5",
              "latency", cyc - it.t0, it.lat);
        check(busy, "R2", "busy with done", busy, 1);
        if (it.rd) check(rd_data == it.data, "R8", "read data", rd_data, it.data);
        was_wr_done = !it.rd;
      end
    end else if (!busy && was_wr_done) begin
      check(mem_we_n == 1'b0, "R5", "we held low in idle", mem_we_n, 0);
      was_wr_done = 0;
    end
    if (!mem_ce_n && !mem_we_n && mem_bs_n != 2'b11) begin
      win_run++;
      check(mem_doe, "R9", "bus driven in window", mem_doe, 1);
    end else if (win_run != 0) begin
      check(win_run == W, "R4", "write window length", win_run, W);
      check(!mem_ce_n && !mem_we_n, "R4", "end by byte selects", {mem_ce_n, mem_we_n}, 0);
      win_run = 0;
    end
    if (!mem_oe_n) begin
      if (p_oe_n) check(p_we_n, "R7", "we high before oe falls", p_we_n, 1);
      oe_run++;
    end else if (oe_run != 0) begin
      check(oe_run == R, "R6", "read window length", oe_run, R);
      oe_run = 0;
    end
    p_oe_n = mem_oe_n; p_we_n = mem_we_n;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check({busy, done, mem_doe} == 3'b000, "R1", "busy/done/doe in reset", {busy, done, mem_doe}, 0);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n} == 5'h1F, "R1", "pins in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n}, 5'h1F);
    rst_n = 1;
    @(negedge clk);
    check({busy, done, mem_ce_n, mem_we_n} == 4'b0011, "R1", "idle after reset",
          {busy, done, mem_ce_n, mem_we_n}, 4'b0011);

    do_op(1, 19'h00010, 16'hAAAA, 2'b11);   // fresh write R3
    do_op(1, 19'h00011, 16'h5555, 2'b11);   // chained write R5
    do_op(0, 19'h00010, 16'h0, 2'b11);      // read after write R7
    do_op(0, 19'h00011, 16'h0, 2'b11);      // plain read R6
    do_op(1, 19'h40000, 16'h1234, 2'b01);   // lower byte only R8
    do_op(1, 19'h40000, 16'hABCD, 2'b10);   // upper byte only R8
    do_op(0, 19'h40000, 16'h0, 2'b01);
    do_op(0, 19'h40000, 16'h0, 2'b10);
    do_op(0, 19'h40000, 16'h0, 2'b11);
    do_op(1, 19'h00020, 16'hFFFF, 2'b00);   // empty mask writes nothing R8
    do_op(0, 19'h00020, 16'h0, 2'b11);
    for (int k = 0; k < 4; k++) do_op(1, 19'h7FF00 + 19'(k), 16'h1111 * 16'(k + 1), 2'b11);
    for (int k = 0; k < 4; k++) do_op(0, 19'h7FF00 + 19'(k), 16'h0, 2'b11);
    // R2: request while busy is ignored
    do_op(0, 19'h00003, 16'h0, 2'b11);
    req_valid = 1; req_write = 1; req_addr = 19'h7FFFF; req_wdata = 16'hDEAD; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 0;
    do_op(0, 19'h7FFFF, 16'h0, 2'b11);
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(dones == issued, "R2", "done count equals accepted", dones, issued);
    check(mem_doe == 1'b0, "R9", "bus released at end", mem_doe, 0);
    summary();
    $finish;
  end
endmodule